// File: doc/BRIEF.md
# Event Flag and Interrupt Aggregator

This block gathers single-cycle event pulses from a set of channels, plus a port-wide detect condition, into flags that software can read and clear through a simple register interface. A level interrupt is raised while any flag is set whose source is enabled. Enables are changed through two registers that share one view of the mask: one sets enable bits, the other clears them.

The detect condition comes from a small latch register. Each latch bit is set while its sense input is high. Software clears latch bits by writing ones. The detect output is the OR of the latch bits, and the port flag is raised only when detect rises. A clear that leaves any latch bit set pulls detect low for one cycle. Detect then rises again, so a source that is still pending raises a fresh port event.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every register reads zero, and both `irq_o` and `detect_o` are low.
- R2: A high on `chan_evt_i[i]` sets channel flag i. The flag reads 1 in bit 0 at offset 0x100 + 4i after the next clock edge.
- R3: Writing a value with bit 0 = 0 to a flag register clears that flag. Writing bit 0 = 1 has no effect. If an event pulse and a clearing write land in the same cycle, the flag stays set.
- R4: The port flag (offset 0x17C, bit 0) is set only on a rising edge of `detect_o`. Once cleared, it stays clear while detect stays high.
- R5: Latch bit j (offset 0x180, bit j) is set whenever `sense_i[j]` is high. Writing 1 to bit j clears it, unless `sense_i[j]` is still high in that cycle. Writing 0 to a bit has no effect on it.
- R6: A latch-clear write that leaves any latch bit set drives `detect_o` low for exactly one cycle. Detect rises again on the next edge, so the port flag is set one cycle after the gap. A clear that empties the latch raises no port event.
- R7: Writing 1 to a bit of the enable-set register (0x304) enables that source. Writing 0 has no effect. Channel i maps to bit i and the port event maps to bit 31. The register reads back the enable mask.
- R8: Writing 1 to a bit of the enable-clear register (0x308) disables that source. Writing 0 has no effect. The register reads back the same mask as 0x304.
- R9: `irq_o` is a level: the OR over all sources of (flag AND enable). It follows the registered state with no extra delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_evt_i | input | NCH | Per-channel event pulses |
| sense_i | input | NSRC | Detect sources feeding the latch |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| detect_o | output | 1 | OR of the latch bits, with the re-arm gap |
| irq_o | output | 1 | Level interrupt |

## Verification
- **One edge:** flags, latch bits, enable bits and `detect_o` all change on the first clock edge after the stimulus. `irq_o` follows in the same cycle, because it is decoded from registered state.
- **Two edges:** after a partial latch clear, the re-raised port flag appears one edge later than the other results, that is, two edges after the write.
- **Sampling:** the bench applies each stimulus for exactly one edge, then removes the write strobe and the pulses. One time unit after that edge it drives a read address and samples `bus_rdata_o`, `irq_o` and `detect_o`.
- **Re-arm case:** for the re-arm case it checks once right after the clearing write (gap present, flag still clear) and again after one more idle edge.

// File: rtl/evt_hub_pkg.sv
package evt_hub_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CHAN  = 12'h100; // channel i at +4*i
    localparam logic [ADDR_W-1:0] OFS_PORT  = 12'h17C;
    localparam logic [ADDR_W-1:0] OFS_LATCH = 12'h180;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h304;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h308;
    // bit position of the port source in the enable registers
    localparam int PORT_BIT = 31;
endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    // a set in the same cycle as a clear wins
    always_comb begin
        flag_d = set_i | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o); // R3
endmodule

// File: rtl/det_latch.sv
module det_latch #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] sense_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] clr_mask_i,
    output logic [NSRC-1:0] latch_o,
    output logic            detect_o,
    output logic            rise_o
);
    typedef struct packed {
        logic [NSRC-1:0] latch;
        logic            det;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    gap;

    always_comb begin
        st_d       = st_q;
        st_d.latch = (st_q.latch & ~(clr_wr_i ? clr_mask_i : '0)) | sense_i;
        // partial clear: hold detect low for one cycle so it can rise again
        gap        = clr_wr_i && (|st_d.latch);
        st_d.det   = (|st_d.latch) && !gap;
        rise_o     = st_d.det && !st_q.det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o  = st_q.latch;
    assign detect_o = st_q.det;

    AST_SENSE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|sense_i) |=> (|latch_o)); // R5
    AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && (|sense_i)) |=> !detect_o); // R6
    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(detect_o) && (|latch_o) && !clr_wr_i) |=> detect_o); // R6
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_hub_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NSRC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_evt_i,
    input  logic [NSRC-1:0]   sense_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              detect_o,
    output logic              irq_o
);
    localparam int NSRC_ALL = NCH + 1; // channels plus port

    typedef struct packed {
        logic [NSRC_ALL-1:0] en;
    } hub_st_t;

    hub_st_t             st_d, st_q;
    logic [NCH-1:0]      chan_flag;
    logic                port_flag;
    logic [NSRC-1:0]     latch;
    logic                det_rise;
    logic [NSRC_ALL-1:0] wmask;
    logic                wr_enset, wr_enclr, wr_port, wr_latch;

    assign wr_enset = bus_wr_i && (bus_addr_i == OFS_ENSET);
    assign wr_enclr = bus_wr_i && (bus_addr_i == OFS_ENCLR);
    assign wr_port  = bus_wr_i && (bus_addr_i == OFS_PORT);
    assign wr_latch = bus_wr_i && (bus_addr_i == OFS_LATCH);
    assign wmask    = {bus_wdata_i[PORT_BIT], bus_wdata_i[NCH-1:0]};

    // per-channel flags
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [ADDR_W-1:0] MY_OFS = OFS_CHAN + ADDR_W'(4 * g);
        evt_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (chan_evt_i[g]),
            .clr_i  (bus_wr_i && (bus_addr_i == MY_OFS) && !bus_wdata_i[0]),
            .flag_o (chan_flag[g])
        );
    end

    det_latch #(.NSRC(NSRC)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .sense_i    (sense_i),
        .clr_wr_i   (wr_latch),
        .clr_mask_i (bus_wdata_i[NSRC-1:0]),
        .latch_o    (latch),
        .detect_o   (detect_o),
        .rise_o     (det_rise)
    );

    evt_flag_cell u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (det_rise),
        .clr_i  (wr_port && !bus_wdata_i[0]),
        .flag_o (port_flag)
    );

    // enable mask: separate set and clear writes
    always_comb begin
        st_d = st_q;
        if (wr_enset) st_d.en = st_d.en | wmask;
        if (wr_enclr) st_d.en = st_d.en & ~wmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr_i == OFS_CHAN + ADDR_W'(4 * i))
                bus_rdata_o = DATA_W'(chan_flag[i]);
        end
        if (bus_addr_i == OFS_PORT)
            bus_rdata_o = DATA_W'(port_flag);
        if (bus_addr_i == OFS_LATCH)
            bus_rdata_o = DATA_W'(latch);
        if (bus_addr_i == OFS_ENSET || bus_addr_i == OFS_ENCLR) begin
            bus_rdata_o[NCH-1:0] = st_q.en[NCH-1:0];
            bus_rdata_o[PORT_BIT] = st_q.en[NCH];
        end
    end

    assign irq_o = |({port_flag, chan_flag} & st_q.en);

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enset && !wr_enclr) |=> ((st_q.en & $past(wmask)) == $past(wmask))); // R7
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enclr |=> ((st_q.en & $past(wmask)) == '0)); // R8
    AST_PORT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(port_flag)) |-> $rose(detect_o)); // R4
endmodule

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int NSRC = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  chan_evt = '0;
    logic [NSRC-1:0] sense = '0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            detect;
    logic            irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    evt_irq_hub #(.NCH(NCH), .NSRC(NSRC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_evt_i  (chan_evt),
        .sense_i     (sense),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .detect_o    (detect),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct packed {
        logic [7:0]  chan;
        logic [3:0]  sns;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [11:0] chk;
        logic [31:0] exp;
        logic        irq_e;
        logic        det_e;
        int          req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 4'h0, 1'b1, 12'h304, 32'h8000_00FF, 12'h304, 32'h8000_00FF, 1'b0, 1'b0, 7}, // R7
        '{8'h00, 4'h0, 1'b1, 12'h308, 32'h0000_00F0, 12'h308, 32'h8000_000F, 1'b0, 1'b0, 8}, // R8
        '{8'h01, 4'h0, 1'b0, 12'h000, 32'h0,         12'h100, 32'h1,         1'b1, 1'b0, 2}, // R2
        '{8'h20, 4'h0, 1'b0, 12'h000, 32'h0,         12'h114, 32'h1,         1'b1, 1'b0, 2}, // R2
        '{8'h00, 4'h0, 1'b1, 12'h100, 32'h0,         12'h100, 32'h0,         1'b0, 1'b0, 3}, // R3, R9
        '{8'h00, 4'h0, 1'b1, 12'h114, 32'h1,         12'h114, 32'h1,         1'b0, 1'b0, 3}, // R3
        '{8'h20, 4'h0, 1'b1, 12'h114, 32'h0,         12'h114, 32'h1,         1'b0, 1'b0, 3}, // R3
        '{8'h00, 4'h3, 1'b0, 12'h000, 32'h0,         12'h17C, 32'h1,         1'b1, 1'b1, 4}, // R4
        '{8'h00, 4'h3, 1'b1, 12'h17C, 32'h0,         12'h17C, 32'h0,         1'b0, 1'b1, 4}, // R4
        '{8'h00, 4'h1, 1'b1, 12'h180, 32'h2,         12'h180, 32'h1,         1'b0, 1'b0, 6}, // R5, R6
        '{8'h00, 4'h1, 1'b0, 12'h000, 32'h0,         12'h17C, 32'h1,         1'b1, 1'b1, 6}  // R6
    };

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock edge of stimulus; pulses and write strobe last one cycle
    task automatic step(input logic [7:0] ch, input logic [3:0] sn, input logic wr,
                        input logic [11:0] ad, input logic [31:0] wd);
        @(negedge clk);
        chan_evt = ch; sense = sn; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
        @(posedge clk);
        #1;
        chan_evt = '0; bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] ad, input logic [31:0] exp);
        bus_addr = ad;
        #1;
        check(tag, $sformatf("read %h", ad), bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd("R1", 12'h100, 32'h0);
        rd("R1", 12'h17C, 32'h0);
        rd("R1", 12'h180, 32'h0);
        rd("R1", 12'h304, 32'h0);
        check("R1", "irq", 32'(irq), 32'h0);
        check("R1", "detect", 32'(detect), 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].chan, VEC[i].sns, VEC[i].wr, VEC[i].addr, VEC[i].wdata);
            rd($sformatf("R%0d", VEC[i].req), VEC[i].chk, VEC[i].exp);
            check($sformatf("R%0d", VEC[i].req), "irq", 32'(irq), 32'(VEC[i].irq_e));
            check($sformatf("R%0d", VEC[i].req), "detect", 32'(detect), 32'(VEC[i].det_e));
        end

        // R5: clear while the source is still high keeps the bit; R6 gap then rise
        step(8'h00, 4'h1, 1'b1, 12'h180, 32'h1);
        rd("R5", 12'h180, 32'h1);
        check("R6", "detect gap", 32'(detect), 32'h0);
        step(8'h00, 4'h1, 1'b0, 12'h000, 32'h0);
        check("R6", "detect back", 32'(detect), 32'h1);

        // R6: emptying the latch raises no port event
        step(8'h00, 4'h0, 1'b1, 12'h17C, 32'h0);
        rd("R4", 12'h17C, 32'h0);
        step(8'h00, 4'h0, 1'b1, 12'h180, 32'hF);
        rd("R5", 12'h180, 32'h0);
        check("R6", "detect after empty", 32'(detect), 32'h0);
        step(8'h00, 4'h0, 1'b0, 12'h000, 32'h0);
        rd("R6", 12'h17C, 32'h0);
        check("R9", "irq none", 32'(irq), 32'h0);

        // R9: level interrupt held, removed by enable-clear (R8)
        step(8'h02, 4'h0, 1'b0, 12'h000, 32'h0);
        check("R9", "irq set", 32'(irq), 32'h1);
        step(8'h00, 4'h0, 1'b0, 12'h000, 32'h0);
        check("R9", "irq held", 32'(irq), 32'h1);
        step(8'h00, 4'h0, 1'b1, 12'h308, 32'h2);
        check("R8", "irq masked", 32'(irq), 32'h0);
        rd("R8", 12'h304, 32'h8000_000D);
        rd("R2", 12'h104, 32'h1);

        // R4: a fresh rising edge from another source
        step(8'h00, 4'h4, 1'b0, 12'h000, 32'h0);
        rd("R4", 12'h17C, 32'h1);
        rd("R5", 12'h180, 32'h4);
        check("R9", "irq port", 32'(irq), 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule